// File: doc/BRIEF.md
# Accumulator ALU with Packed Status Word

This block is the arithmetic heart of a small 8-bit processor datapath. It holds an accumulator and a packed status byte. Each accepted operation combines the accumulator with an operand byte and writes the result back to the accumulator. Depending on the operation, it also updates the carry, nibble-carry and signed-overflow flags. A parity flag follows the accumulator value in every cycle, not only after operations.

The status byte also carries a software flag and a two-bit register-bank selector. The selector is turned into a base address for an external register file. A direct write port loads the status byte in one cycle. Instruction decode, the register file and memory sit outside the block.

Operations arrive on a valid/ready interface. The block never applies back-pressure in normal running: ready is high in every cycle except during reset. An operation takes effect at the clock edge where both valid and ready are high. While valid is low, nothing is consumed and the accumulator holds its value.

Top module: `acc_alu_core`

## Requirements
- R1: A synchronous reset clears the accumulator and the whole status byte to 00H, and op_ready is low while reset is asserted.
- R2: ADD gives A+operand and ADDC gives A+operand+CY. CY is the carry out of bit 7, AC is the carry from bit 3 into bit 4, and OV flags a two's-complement overflow. For example, A=9BH plus 65H gives A=00H, CY=1, AC=1, OV=0, P=0.
- R3: SUBB gives A−operand−CY. CY is the borrow out of bit 7, AC is the borrow into bit 3, and OV flags a two's-complement overflow.
- R4: AND, OR, XOR, CLR (A becomes 00H) and CPL (A becomes ~A) leave CY, AC and OV unchanged.
- R5: RL and RR rotate A by one bit and change no flag. RLC moves CY into bit 0 and loads CY from the old bit 7. RRC moves CY into bit 7 and loads CY from the old bit 0. Neither touches AC or OV.
- R6: Status bit 0 (P) is 1 exactly when the accumulator currently holds an odd number of one bits.
- R7: Status bit 5 (F0) is never changed by an operation; only a direct status write changes it.
- R8: bank_base equals {status[4], status[3], 3'b000}, giving base 00H, 08H, 10H or 18H.
- R9: A status write (psw_wr_en) loads status bits 7..1 from psw_wr_data at the next edge. It overrides any flag update from an operation in the same cycle, while the accumulator still takes that operation's result. Bit 1 is kept as written, and P is always recomputed.
- R10: An operation is applied only when op_valid and op_ready are both high. Otherwise the accumulator and the flags hold their values.
- R11: The op_code values are ADD=0, ADDC=1, SUBB=2, AND=3, OR=4, XOR=5, RL=6, RR=7, RLC=8, RRC=9, CLR=10 and CPL=11. Codes 12 to 15 are accepted but change neither the accumulator nor any flag.
- R12: The status byte is laid out, from bit 7 down, as CY, AC, F0, RS1, RS0, OV, a spare bit and P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request is present |
| op_ready | output | 1 | Block accepts an operation this cycle |
| op_code | input | 4 | Operation select (see R11) |
| operand | input | 8 | Second operand byte |
| psw_wr_en | input | 1 | Load status byte this cycle |
| psw_wr_data | input | 8 | Status byte to load |
| acc_out | output | 8 | Accumulator value |
| psw_out | output | 8 | Status byte (layout in R12) |
| bank_base | output | 5 | Register-file bank base address |

## Verification
Directed sequences come first. They cover the 9BH+65H case, which yields carry and nibble carry with a zero result. Signed overflow is reached from both directions, and borrows are forced from both the low and the high nibble, so that CY, AC and OV can each be told apart from the others. Every logic op and rotate then runs with carry preset both set and clear, which separates rotate-through-carry from plain rotate and shows that logic ops leave the arithmetic flags alone. Status writes that collide with operations and all four bank selects check priority and the base mapping. A long pseudo-random run mixes opcodes, idle cycles and writes, and is compared each clock against a behavioural model.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUBB = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_RL   = 4'd6,
    OP_RR   = 4'd7,
    OP_RLC  = 4'd8,
    OP_RRC  = 4'd9,
    OP_CLR  = 4'd10,
    OP_CPL  = 4'd11
  } alu_op_e;

  // status byte bit positions (R12)
  localparam int unsigned ST_CY  = 7;
  localparam int unsigned ST_AC  = 6;
  localparam int unsigned ST_F0  = 5;
  localparam int unsigned ST_RS1 = 4;
  localparam int unsigned ST_RS0 = 3;
  localparam int unsigned ST_OV  = 2;
  localparam int unsigned ST_P   = 0;
  localparam int unsigned ST_W   = 8;

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              sub,
  output logic [DATA_W-1:0] res,
  output logic              cy,
  output logic              ac,
  output logic              ov
);
  localparam int unsigned HALF = DATA_W / 2;

  logic [DATA_W-1:0] bx;
  logic              cx;
  logic [HALF:0]     lo_sum;
  logic [HALF:0]     hi_sum;

  // subtraction as a + ~b + ~borrow; carries invert into borrows
  always_comb begin
    bx     = sub ? ~b : b;
    cx     = sub ? ~cin : cin;
    lo_sum = {1'b0, a[HALF-1:0]} + {1'b0, bx[HALF-1:0]} + {{HALF{1'b0}}, cx};
    hi_sum = {1'b0, a[DATA_W-1:HALF]} + {1'b0, bx[DATA_W-1:HALF]}
           + {{HALF{1'b0}}, lo_sum[HALF]};
    res    = {hi_sum[HALF-1:0], lo_sum[HALF-1:0]};
    cy     = hi_sum[HALF] ^ sub;
    ac     = lo_sum[HALF] ^ sub;
    ov     = (a[DATA_W-1] == bx[DATA_W-1]) && (res[DATA_W-1] != a[DATA_W-1]);
  end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cy_new,
  output logic              cy_upd
);

  always_comb begin
    res    = a;
    cy_new = cin;
    cy_upd = 1'b0;
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_RL:   res = {a[DATA_W-2:0], a[DATA_W-1]};
      OP_RR:   res = {a[0], a[DATA_W-1:1]};
      OP_RLC: begin
        res    = {a[DATA_W-2:0], cin};
        cy_new = a[DATA_W-1];
        cy_upd = 1'b1;
      end
      OP_RRC: begin
        res    = {cin, a[DATA_W-1:1]};
        cy_new = a[0];
        cy_upd = 1'b1;
      end
      OP_CLR:  res = '0;
      OP_CPL:  res = ~a;
      default: res = a;
    endcase
  end

endmodule

// File: rtl/acc_alu_status.sv
module acc_alu_status
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BANK_SHIFT = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ST_W-1:0]         wr_data,
  input  logic                    upd_arith,
  input  logic                    upd_cy,
  input  logic                    cy_in,
  input  logic                    ac_in,
  input  logic                    ov_in,
  input  logic [DATA_W-1:0]       acc,
  output logic                    cy_q,
  output logic [ST_W-1:0]         status,
  output logic [BANK_SHIFT+1:0]   bank_base
);
  logic [ST_W-1:1] st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else if (wr_en) begin
      st_q <= wr_data[ST_W-1:1];
    end else if (upd_arith) begin
      st_q[ST_CY] <= cy_in;
      st_q[ST_AC] <= ac_in;
      st_q[ST_OV] <= ov_in;
    end else if (upd_cy) begin
      st_q[ST_CY] <= cy_in;
    end
  end

  always_comb begin
    cy_q      = st_q[ST_CY];
    status    = {st_q, ^acc};
    bank_base = {st_q[ST_RS1], st_q[ST_RS0], {BANK_SHIFT{1'b0}}};
  end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BANK_SHIFT = 3,
  localparam int unsigned BASE_W    = BANK_SHIFT + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] operand,
  input  logic              psw_wr_en,
  input  logic [ST_W-1:0]   psw_wr_data,
  output logic [DATA_W-1:0] acc_out,
  output logic [ST_W-1:0]   psw_out,
  output logic [BASE_W-1:0] bank_base
);
  logic [DATA_W-1:0] acc_q;
  logic              fire;
  logic              is_arith;
  logic              is_sub;
  logic              carry_q;
  logic              arith_cin;
  logic [DATA_W-1:0] arith_res;
  logic              arith_cy;
  logic              arith_ac;
  logic              arith_ov;
  logic [DATA_W-1:0] logic_res;
  logic              logic_cy;
  logic              logic_cy_upd;
  logic              cy_sel;

  always_comb begin
    op_ready  = ~rst;
    fire      = op_valid & op_ready;
    is_arith  = (op_code == OP_ADD) || (op_code == OP_ADDC) || (op_code == OP_SUBB);
    is_sub    = (op_code == OP_SUBB);
    arith_cin = (op_code != OP_ADD) & carry_q;
    cy_sel    = is_arith ? arith_cy : logic_cy;
  end

  acc_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a   (acc_q),
    .b   (operand),
    .cin (arith_cin),
    .sub (is_sub),
    .res (arith_res),
    .cy  (arith_cy),
    .ac  (arith_ac),
    .ov  (arith_ov)
  );

  acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op     (op_code),
    .a      (acc_q),
    .b      (operand),
    .cin    (carry_q),
    .res    (logic_res),
    .cy_new (logic_cy),
    .cy_upd (logic_cy_upd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (fire) begin
      acc_q <= is_arith ? arith_res : logic_res;
    end
  end

  acc_alu_status #(.DATA_W(DATA_W), .BANK_SHIFT(BANK_SHIFT)) u_status (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (psw_wr_en),
    .wr_data   (psw_wr_data),
    .upd_arith (fire & is_arith),
    .upd_cy    (fire & logic_cy_upd),
    .cy_in     (cy_sel),
    .ac_in     (arith_ac),
    .ov_in     (arith_ov),
    .acc       (acc_q),
    .cy_q      (carry_q),
    .status    (psw_out),
    .bank_base (bank_base)
  );

  assign acc_out = acc_q;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       op_valid,
  input logic       op_ready,
  input logic [3:0] op_code,
  input logic [7:0] operand,
  input logic       psw_wr_en,
  input logic [7:0] psw_wr_data,
  input logic [7:0] acc_out,
  input logic [7:0] psw_out,
  input logic [4:0] bank_base
);
  logic fire_nw;
  logic logic_op;
  always_comb begin
    fire_nw  = op_valid && op_ready && !psw_wr_en;
    logic_op = (op_code == OP_AND) || (op_code == OP_OR) || (op_code == OP_XOR) ||
               (op_code == OP_CLR) || (op_code == OP_CPL) ||
               (op_code == OP_RL)  || (op_code == OP_RR);
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (acc_out == 8'h00 && psw_out == 8'h00)); // R1
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (rst) (fire_nw && op_code == OP_ADD) |=> (psw_out[ST_CY] == ((9'($past(acc_out)) + 9'($past(operand))) > 9'h0FF))); // R2
  AST_LOGIC_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst) (fire_nw && logic_op) |=> $stable({psw_out[ST_CY], psw_out[ST_AC], psw_out[ST_OV]})); // R4
  AST_RLC_CARRY: assert property (@(posedge clk) disable iff (rst) (fire_nw && op_code == OP_RLC) |=> (psw_out[ST_CY] == $past(acc_out[7]))); // R5
  AST_F0_HELD: assert property (@(posedge clk) disable iff (rst) !psw_wr_en |=> $stable(psw_out[ST_F0])); // R7
  AST_BANK_FROM_WRITE: assert property (@(posedge clk) disable iff (rst) psw_wr_en |=> (bank_base == {$past(psw_wr_data[4:3]), 3'b000})); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst) psw_wr_en |=> (psw_out[7:1] == $past(psw_wr_data[7:1]))); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) !(op_valid && op_ready) |=> $stable(acc_out)); // R10

endmodule

bind acc_alu_core acc_alu_chk u_chk (.*);

// File: tb/sim_acc_alu_core.sv
module sim_acc_alu_core;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic       op_ready;
  logic [3:0] op_code = 4'd0;
  logic [7:0] operand = 8'd0;
  logic       psw_wr_en = 1'b0;
  logic [7:0] psw_wr_data = 8'd0;
  logic [7:0] acc_out;
  logic [7:0] psw_out;
  logic [4:0] bank_base;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_acc = 8'h00;
  logic [7:0] m_flg = 8'h00;  // bits 7..1 meaningful
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu_core u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .operand(operand), .psw_wr_en(psw_wr_en),
    .psw_wr_data(psw_wr_data), .acc_out(acc_out), .psw_out(psw_out),
    .bank_base(bank_base)
  );

  function automatic logic [7:0] exp_psw();
    return {m_flg[7:1], logic'($countones(m_acc) % 2 == 1)};
  endfunction

  function automatic int sgn(input logic [7:0] v);
    return (v > 8'd127) ? int'(v) - 256 : int'(v);
  endfunction

  task automatic model_edge();
    int a, b, c, s, sr;
    logic [7:0] na;
    logic ncy, nac, nov;
    if (rst) begin
      m_acc = 8'h00;
      m_flg = 8'h00;
      return;
    end
    na = m_acc; ncy = m_flg[7]; nac = m_flg[6]; nov = m_flg[2];
    a = int'(m_acc); b = int'(operand); c = int'(m_flg[7]);
    if (op_valid) begin
      case (op_code)
        4'd0, 4'd1: begin
          if (op_code == 4'd0) c = 0;
          s = a + b + c;
          na = s[7:0];
          ncy = (s > 255);
          nac = ((a % 16) + (b % 16) + c) > 15;
          sr = sgn(m_acc) + sgn(operand) + c;
          nov = (sr > 127) || (sr < -128);
        end
        4'd2: begin
          s = a - b - c;
          na = s[7:0];
          ncy = (s < 0);
          nac = ((a % 16) - (b % 16) - c) < 0;
          sr = sgn(m_acc) - sgn(operand) - c;
          nov = (sr > 127) || (sr < -128);
        end
        4'd3: na = m_acc & operand;
        4'd4: na = m_acc | operand;
        4'd5: na = m_acc ^ operand;
        4'd6: na = 8'((a * 2) % 256 + a / 128);
        4'd7: na = 8'(a / 2 + (a % 2) * 128);
        4'd8: begin na = 8'((a * 2) % 256 + c); ncy = (a >= 128); end
        4'd9: begin na = 8'(a / 2 + c * 128); ncy = (a % 2 == 1); end
        4'd10: na = 8'h00;
        4'd11: na = 8'(255 - a);
        default: na = m_acc;
      endcase
    end
    m_acc = na;
    if (psw_wr_en) m_flg = {psw_wr_data[7:1], 1'b0};
    else begin m_flg[7] = ncy; m_flg[6] = nac; m_flg[2] = nov; end
  endtask

  task automatic compare(input string tag);
    n_vec++;
    if (acc_out !== m_acc || psw_out !== exp_psw() ||
        bank_base !== {m_flg[4:3], 3'b000} || op_ready !== !rst) begin
      n_bad++;
      $display("FAIL %s: acc/psw/base/rdy got %h/%h/%h/%b expected %h/%h/%h/%b",
               tag, acc_out, psw_out, bank_base, op_ready,
               m_acc, exp_psw(), {m_flg[4:3], 3'b000}, !rst);
    end
  endtask

  // drive inputs, advance one edge, compare at the next falling edge
  task automatic step(input string tag, input logic v, input logic [3:0] op,
                      input logic [7:0] b, input logic we = 1'b0,
                      input logic [7:0] wd = 8'h00);
    op_valid = v; op_code = op; operand = b; psw_wr_en = we; psw_wr_data = wd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic expect_val(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset, with ignored traffic
    rst = 1'b1;
    step("R1 reset", 1'b1, 4'd11, 8'h00, 1'b1, 8'hFF);
    step("R1 reset", 1'b1, 4'd0, 8'h55);
    expect_val("R1 acc", acc_out, 8'h00);
    expect_val("R1 psw", psw_out, 8'h00);
    expect_val("R1 ready", {7'd0, op_ready}, 8'h00);
    rst = 1'b0;
    step("R10 idle", 1'b0, 4'd0, 8'h12);

    // R2: the 9B + 65 case
    step("R2 add", 1'b1, 4'd0, 8'h9B);
    step("R2 add", 1'b1, 4'd0, 8'h65);
    expect_val("R2 acc", acc_out, 8'h00);
    expect_val("R2 cy/ac/ov/p", {psw_out[7], psw_out[6], psw_out[2], psw_out[0]}, 8'b1100);
    step("R2 addc", 1'b1, 4'd1, 8'h7F);                  // 0+7F+1 = 80, OV
    expect_val("R2 ov", {7'd0, psw_out[2]}, 8'h01);
    step("R2 add", 1'b1, 4'd0, 8'h80);                   // 80+80, CY and OV
    step("R2 addc", 1'b1, 4'd1, 8'h0F);

    // R3: subtract with borrow
    step("R3 clr", 1'b1, 4'd10, 8'h00);
    step("R3 subb", 1'b1, 4'd2, 8'h01);                  // 00-01 borrow
    expect_val("R3 acc", acc_out, 8'hFF);
    expect_val("R3 cy/ac", {6'd0, psw_out[7], psw_out[6]}, 8'h03);
    step("R3 subb", 1'b1, 4'd2, 8'h7E);                  // FF-7E-1 = 80
    step("R3 subb", 1'b1, 4'd2, 8'h01);                  // 80-01 = 7F, OV
    expect_val("R3 ov", {7'd0, psw_out[2]}, 8'h01);
    step("R3 subb", 1'b1, 4'd2, 8'h08);

    // R4 / R5 with carry both set and clear
    for (int k = 0; k < 2; k++) begin
      step("R9 set cy", 1'b0, 4'd0, 8'h00, 1'b1, k ? 8'hC4 : 8'h00);
      step("R4 cpl", 1'b1, 4'd11, 8'h00);
      step("R4 and", 1'b1, 4'd3, 8'hA5);
      step("R4 or", 1'b1, 4'd4, 8'h18);
      step("R4 xor", 1'b1, 4'd5, 8'hFF);
      step("R5 rl", 1'b1, 4'd6, 8'h00);
      step("R5 rr", 1'b1, 4'd7, 8'h00);
      step("R5 rlc", 1'b1, 4'd8, 8'h00);
      step("R5 rlc", 1'b1, 4'd8, 8'h00);
      step("R5 rrc", 1'b1, 4'd9, 8'h00);
      step("R5 rrc", 1'b1, 4'd9, 8'h00);
      step("R4 clr", 1'b1, 4'd10, 8'h00);
    end

    // R6: parity follows acc through loads of different weight
    step("R6 or", 1'b1, 4'd4, 8'h01);
    expect_val("R6 p odd", {7'd0, psw_out[0]}, 8'h01);
    step("R6 or", 1'b1, 4'd4, 8'h02);
    expect_val("R6 p even", {7'd0, psw_out[0]}, 8'h00);

    // R7: F0 set by write survives arithmetic
    step("R7 wr f0", 1'b0, 4'd0, 8'h00, 1'b1, 8'h20);
    step("R7 add", 1'b1, 4'd0, 8'hFF);
    step("R7 subb", 1'b1, 4'd2, 8'h33);
    expect_val("R7 f0", {7'd0, psw_out[5]}, 8'h01);

    // R8: every bank select, plus the spare bit kept (R9)
    for (int k = 0; k < 4; k++) begin
      step("R8 bank", 1'b0, 4'd0, 8'h00, 1'b1, {3'b000, 2'(k), 3'b010});
      expect_val("R8 base", {3'd0, bank_base}, 8'(k * 8));
      expect_val("R9 spare", {7'd0, psw_out[1]}, 8'h01);
    end

    // R9: write colliding with an ADD: acc updates, flags from write
    step("R9 clr", 1'b1, 4'd10, 8'h00);
    step("R9 add", 1'b1, 4'd0, 8'hF0);
    step("R9 collide", 1'b1, 4'd0, 8'h20, 1'b1, 8'h00);
    expect_val("R9 acc", acc_out, 8'h10);
    expect_val("R9 psw", psw_out, 8'h01);

    // R10 / R11: idle and reserved codes
    step("R10 idle", 1'b0, 4'd11, 8'h00);
    for (int k = 12; k < 16; k++) step("R11 reserved", 1'b1, 4'(k), 8'hFF);
    expect_val("R11 acc", acc_out, 8'h10);

    // random mix
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R12 random", lfsr[0] | lfsr[1] | lfsr[2], 4'(lfsr[7:4] % 13),
           lfsr[15:8], lfsr[3] & lfsr[9] & lfsr[11], lfsr[15:8] ^ 8'h5A);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule